// File: doc/BRIEF.md
# Byte-Exchange Serial Master Port

This block is a register-mapped serial master for a processor bus. Software sets up a control register, then writes a byte to the data register. That write launches one 8-bit full-duplex exchange. The block drives the serial clock and the outgoing data line, and it captures the incoming line on the opposite phase. When the eighth bit has been exchanged, the received byte appears in the data register and a sticky completion flag is raised. The flag can request an interrupt.

The control register selects the following: enable, master operation, bit order, clock idle level, clock phase, interrupt enable and a two-bit rate field. The status register holds the completion flag and a collision flag, both read-only, and a writable double-speed bit. The chip-select line of the attached device is not part of this block; software drives it from a general-purpose output around each command.

Register addresses: 0 is control, 1 is status, 2 is data, and 3 reads as zero. Control bits, from bit 0 upward: enable, master, lsb_first, cpol, cpha, irq_en, then rate in bits 7:6. Status bits: bit 0 completion, bit 1 collision, bit 2 double-speed.

Top module: `spi_host_port`

## Requirements
- R1: After reset, the control, status and data registers all read 0x00, `sck` is low and `irq` is low.
- R2: Whenever no exchange is running, or the port is disabled, `sck` sits at the cpol level (control bit 3).
- R3: An exchange produces exactly 16 `sck` transitions. The half-period is H system clocks, with H = 2, 8, 32 or 64 for rate values 0 to 3. Setting the double-speed bit (status bit 2) halves H. The first transition comes H cycles after the write cycle.
- R4: A data write with enable=1 and master=1 while idle exchanges the written byte for the byte on `miso`. With cpha=0 (control bit 4), `miso` is sampled on the first edge of each bit cell and `mosi` changes on the second edge. With cpha=1, the roles of the two edges swap. This holds for all four cpol/cpha combinations. A data read returns the received byte.
- R5: With lsb_first=0 (control bit 2), bit 7 is sent and received first. With lsb_first=1, bit 0 is sent and received first.
- R6: The completion flag (status bit 0) rises the cycle after the last edge. `irq` is high exactly while that flag and irq_en (control bit 5) are both 1.
- R7: A data write while an exchange runs sets the collision flag (status bit 1). That write is otherwise ignored, and the running exchange finishes unchanged.
- R8: Both flags stay set until a status read that observed them is followed by a data-register read or write. That data access clears only the flags the status read observed.
- R9: With enable=0, data writes start nothing and set no flag. Clearing enable during an exchange aborts it: no completion flag is set and `sck` returns to the cpol level.
- R10: Writing the status register changes only the double-speed bit. The completion and collision flags ignore such writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the following for granted:
- Each bus strobe lasts one cycle.
- A read and a write never coincide.
- Software does not change cpha, cpol, lsb_first or the rate while an exchange runs. Clearing enable to abort an exchange is the one allowed change.

The stimulus keeps within these rules. Every register access is a single-cycle pulse driven away from the clock edge. Control is reprogrammed only after the bench's reference model reports the exchange as finished, apart from one deliberate mid-exchange disable. The attached serial device is modelled behaviourally: it reacts to `sck` edges on the pin itself, so bit order and phase are checked from the outside.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int EDGE_W = IDX_W + 1;
  localparam int HALF_W = 7;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    logic       irq_en;
    logic       cpha;
    logic       cpol;
    logic       lsb_first;
    logic       master;
    logic       enable;
  } ctrl_t;

  // Half-period of sck in system clocks: 2, 8, 32, 64, halved by dbl.
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate,
                                                    input logic dbl);
    logic [HALF_W-1:0] base;
    if (rate == 2'd3) base = HALF_W'(64);
    else              base = HALF_W'(2) << {rate, 1'b0};
    return dbl ? (base >> 1) : base;
  endfunction

  // Position in the byte of the n-th bit on the wire.
  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] n,
                                               input logic lsb_first);
    return lsb_first ? n : (IDX_W'(BYTE_W - 1) - n);
  endfunction
endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              xfer_done,
  input  logic              wcol_evt,
  output ctrl_t             ctrl_q,
  output logic              dbl_q,
  output logic              done_flag,
  output logic              wcol_flag,
  output logic              data_wr,
  output logic              data_acc,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic stat_rd;
  logic seen_done, seen_wcol;

  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == A_DATA);
  assign stat_rd  = bus_rd && (bus_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dbl_q     <= 1'b0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      seen_done <= 1'b0;
      seen_wcol <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_wr && bus_addr == A_STAT) dbl_q  <= bus_wdata[2];
      if (stat_rd) begin
        seen_done <= done_flag;
        seen_wcol <= wcol_flag;
      end
      if (data_acc) begin
        if (seen_done) done_flag <= 1'b0;
        if (seen_wcol) wcol_flag <= 1'b0;
        seen_done <= 1'b0;
        seen_wcol <= 1'b0;
      end
      if (xfer_done) done_flag <= 1'b1;
      if (wcol_evt)  wcol_flag <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {{(BYTE_W-3){1'b0}}, dbl_q, wcol_flag, done_flag};
      A_DATA:  bus_rdata = rx_byte;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_host_tick.sv
module spi_host_tick
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic              at_end;

  assign at_end = (cnt == half - HALF_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [HALF_W-1:0] half_in,
  input  logic              tick,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              miso,
  output logic              busy,
  output logic [HALF_W-1:0] half_q,
  output logic              phase,
  output logic              mosi,
  output logic              xfer_done,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [EDGE_W-1:0] edge_q, edge_inc;
  logic [IDX_W-1:0]  out_idx;
  logic [BYTE_W-1:0] tx_q, rx_q, rx_ins;
  logic              sample_now, shift_now, last_edge;

  assign edge_inc   = edge_q + EDGE_W'(1);
  assign last_edge  = (edge_q == '1);
  assign sample_now = busy && en && tick && (edge_q[0] == cpha);
  assign shift_now  = busy && en && tick && (edge_q[0] != cpha);
  assign xfer_done  = busy && en && tick && last_edge;
  assign mosi       = tx_q[bit_pos(out_idx, lsb_first)];

  always_comb begin
    rx_ins = rx_q;
    if (sample_now) rx_ins[bit_pos(edge_q[EDGE_W-1:1], lsb_first)] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      edge_q  <= '0;
      out_idx <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_byte <= '0;
      half_q  <= HALF_W'(1);
    end else if (!en) begin
      busy  <= 1'b0;
      phase <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      phase   <= 1'b0;
      edge_q  <= '0;
      out_idx <= '0;
      tx_q    <= wdata;
      rx_q    <= '0;
      half_q  <= half_in;
    end else if (busy && tick) begin
      phase  <= ~phase;
      edge_q <= edge_inc;
      rx_q   <= rx_ins;
      if (shift_now) out_idx <= edge_inc[EDGE_W-1:1];
      if (last_edge) begin
        busy    <= 1'b0;
        rx_byte <= rx_ins;
      end
    end
  end
endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              dbl_q, done_flag, wcol_flag, data_wr, data_acc;
  logic              busy, phase, edge_tick, xfer_done;
  logic              start_xfer, wcol_evt, may_run;
  logic [HALF_W-1:0] half_q, half_sel;
  logic [BYTE_W-1:0] rx_byte;

  assign may_run    = ctrl_q.enable && ctrl_q.master;
  assign start_xfer = data_wr && may_run && !busy;
  assign wcol_evt   = data_wr && may_run && busy;
  assign half_sel   = half_period(ctrl_q.rate, dbl_q);
  assign sck        = (ctrl_q.enable && phase) ^ ctrl_q.cpol;
  assign irq        = done_flag && ctrl_q.irq_en;

  spi_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_byte(rx_byte),
    .xfer_done(xfer_done), .wcol_evt(wcol_evt), .ctrl_q(ctrl_q),
    .dbl_q(dbl_q), .done_flag(done_flag), .wcol_flag(wcol_flag),
    .data_wr(data_wr), .data_acc(data_acc), .bus_rdata(bus_rdata)
  );

  spi_host_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy && ctrl_q.enable),
    .half(half_q), .tick(edge_tick)
  );

  spi_host_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.enable), .start(start_xfer),
    .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first), .half_in(half_sel),
    .tick(edge_tick), .wdata(bus_wdata), .miso(miso), .busy(busy),
    .half_q(half_q), .phase(phase), .mosi(mosi), .xfer_done(xfer_done),
    .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_host_port_chk.sv
module spi_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [7:0] ctrl,
  input logic       busy,
  input logic       start,
  input logic       tick,
  input logic       xfer_done,
  input logic       wcol_evt,
  input logic       done_flag,
  input logic       wcol_flag,
  input logic       data_acc,
  input logic       irq
);
  logic en, cpol, irq_en;
  assign en     = ctrl[0];
  assign cpol   = ctrl[3];
  assign irq_en = ctrl[5];

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !en) |-> (sck == cpol));
  p_tick_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);
  p_sck_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !tick) |=> ($stable(sck) || !$stable(ctrl)));
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !busy);
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_flag);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_wcol_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |-> !start);
  p_wcol_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol_flag);
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !data_acc) |=> done_flag);
  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_flag && !data_acc) |=> wcol_flag);
  p_off_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !start);
endmodule

bind spi_host_port spi_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .ctrl(ctrl_q), .busy(busy),
  .start(start_xfer), .tick(edge_tick), .xfer_done(xfer_done),
  .wcol_evt(wcol_evt), .done_flag(done_flag), .wcol_flag(wcol_flag),
  .data_acc(data_acc), .irq(irq)
);

// File: tb/spi_host_port_test.sv
module spi_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  int checks = 0, failures = 0;

  spi_host_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  bit m_busy, m_phase, m_done, m_wcol, a_d, a_w;
  bit m_en, m_master, m_lsb, m_cpol, m_cpha, m_ie, m_dbl;
  bit [1:0] m_rate;
  int m_cnt, m_half, m_edges;
  bit model_on = 0;

  function automatic int ref_half(input bit [1:0] r, input bit d);
    int v;
    case (r)
      2'd0: v = 2;
      2'd1: v = 8;
      2'd2: v = 32;
      default: v = 64;
    endcase
    return d ? v / 2 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_done = 0; m_wcol = 0; a_d = 0; a_w = 0;
      {m_rate, m_ie, m_cpha, m_cpol, m_lsb, m_master, m_en} = 8'h00;
      m_dbl = 0; m_cnt = 0; m_half = 2; m_edges = 0;
    end else begin
      bit was_busy, fin, coll;
      was_busy = m_busy; fin = 0; coll = 0;
      if (m_busy) begin
        if (!m_en) begin m_busy = 0; m_phase = 0; end
        else begin
          m_cnt++;
          if (m_cnt == m_half) begin
            m_cnt = 0; m_phase = !m_phase; m_edges++;
            if (m_edges == 16) begin m_busy = 0; fin = 1; end
          end
        end
      end
      if (bus_wr && bus_addr == 2'd2 && m_en && m_master) begin
        if (was_busy) coll = 1;
        else begin
          m_busy = 1; m_cnt = 0; m_edges = 0; m_phase = 0;
          m_half = ref_half(m_rate, m_dbl);
        end
      end
      if (bus_rd && bus_addr == 2'd1) begin a_d = m_done; a_w = m_wcol; end
      if ((bus_rd || bus_wr) && bus_addr == 2'd2) begin
        if (a_d) m_done = 0;
        if (a_w) m_wcol = 0;
        a_d = 0; a_w = 0;
      end
      if (fin)  m_done = 1;
      if (coll) m_wcol = 1;
      if (bus_wr && bus_addr == 2'd0)
        {m_rate, m_ie, m_cpha, m_cpol, m_lsb, m_master, m_en} = bus_wdata;
      if (bus_wr && bus_addr == 2'd1) m_dbl = bus_wdata[2];
    end
  end

  // per-clock comparison of sck timing (R2, R3) and irq (R6)
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(sck == ((m_en && m_phase) ^ m_cpol), "R3", "sck vs model", sck,
          (m_en && m_phase) ^ m_cpol);
      chk(irq == (m_done && m_ie), "R6", "irq vs model", irq, m_done && m_ie);
    end
  end

  // ---------------- behavioural serial device ----------------
  bit s_active = 0, s_cpha, s_lsb;
  bit [7:0] s_tx, s_rx;
  int s_e;

  function automatic int wpos(input int j, input bit lsb);
    return lsb ? j : 7 - j;
  endfunction

  always @(sck) begin
    if (s_active) begin
      if ((s_e % 2) == int'(s_cpha)) s_rx[wpos(s_e / 2, s_lsb)] = mosi;
      else if (s_e >= 1 && (s_e + 1) / 2 < 8) miso = s_tx[wpos((s_e + 1) / 2, s_lsb)];
      s_e++;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && m_busy; i++) @(negedge clk);
    chk(!m_busy, "R3", "exchange finished in time", m_busy, 0);
  endtask

  task automatic arm_slave(input bit cpha, input bit lsb, input logic [7:0] sb);
    s_cpha = cpha; s_lsb = lsb; s_tx = sb; s_rx = 8'h00; s_e = 0;
    miso = sb[wpos(0, lsb)];
    s_active = 1;
  endtask

  task automatic do_xfer(input bit cpol, input bit cpha, input bit lsb,
                         input logic [1:0] rate, input bit dbl, input bit ie,
                         input logic [7:0] mb, input logic [7:0] sb,
                         input string req);
    logic [7:0] v;
    bus_write(2'd1, {5'b0, dbl, 2'b0});
    bus_write(2'd0, {rate, ie, cpha, cpol, lsb, 1'b1, 1'b1});
    chk(sck == cpol, "R2", "idle level before exchange", sck, cpol);
    arm_slave(cpha, lsb, sb);
    bus_write(2'd2, mb);
    wait_idle();
    s_active = 0;
    chk(s_e == 16, "R3", "sck transitions per byte", s_e, 16);
    chk(s_rx == mb, req, "byte seen by device", s_rx, mb);
    if (ie) chk(irq == 1'b1, "R6", "irq with irq_en", irq, 1);
    else    chk(irq == 1'b0, "R6", "irq without irq_en", irq, 0);
    bus_read(2'd1, v);
    chk(v[0] == 1'b1, "R6", "completion flag", v[0], 1);
    bus_read(2'd2, v);
    chk(v == sb, req, "received byte", v, sb);
    bus_read(2'd1, v);
    chk(v[1:0] == 2'b00, "R8", "flags cleared by status+data", v[1:0], 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);
    // R1 reset state
    chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
    chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
    bus_read(2'd0, v); chk(v == 8'h00, "R1", "control after reset", v, 0);
    bus_read(2'd1, v); chk(v == 8'h00, "R1", "status after reset", v, 0);
    bus_read(2'd2, v); chk(v == 8'h00, "R1", "data after reset", v, 0);

    // R9 disabled: data write ignored
    bus_write(2'd2, 8'h5A);
    repeat (20) @(negedge clk);
    chk(sck == 1'b0, "R9", "sck while disabled", sck, 0);
    bus_read(2'd1, v); chk(v == 8'h00, "R9", "no flags while disabled", v, 0);
    bus_read(2'd2, v); chk(v == 8'h00, "R9", "data unchanged while disabled", v, 0);

    // R10 flags read-only, dbl writable
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v); chk(v == 8'h04, "R10", "status after writing ones", v, 8'h04);
    bus_write(2'd1, 8'h00);

    // R4 / R5 modes, orders, rates
    do_xfer(0, 0, 0, 2'd0, 0, 0, 8'hA5, 8'h3C, "R4");
    do_xfer(1, 1, 0, 2'd0, 0, 1, 8'hC3, 8'h96, "R4");
    do_xfer(0, 1, 1, 2'd1, 0, 0, 8'h81, 8'h7E, "R5");
    do_xfer(1, 0, 1, 2'd0, 1, 1, 8'h12, 8'hED, "R5");
    do_xfer(0, 0, 1, 2'd3, 0, 0, 8'h01, 8'h80, "R5");
    do_xfer(1, 1, 0, 2'd2, 1, 0, 8'h6B, 8'hD4, "R4");

    // R7 collision
    bus_write(2'd0, {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
    arm_slave(0, 0, 8'h55);
    bus_write(2'd2, 8'h9C);
    repeat (20) @(negedge clk);
    bus_write(2'd2, 8'hFF);
    wait_idle();
    s_active = 0;
    chk(s_rx == 8'h9C, "R7", "exchange unaffected by collision", s_rx, 8'h9C);
    bus_read(2'd1, v); chk(v[1:0] == 2'b11, "R7", "completion and collision", v[1:0], 3);
    bus_read(2'd2, v); chk(v == 8'h55, "R7", "received byte after collision", v, 8'h55);
    bus_read(2'd1, v); chk(v[1:0] == 2'b00, "R8", "both flags cleared", v[1:0], 0);

    // R8 data access without prior status read does not clear
    arm_slave(0, 0, 8'h24);
    bus_write(2'd2, 8'h42);
    wait_idle();
    s_active = 0;
    bus_read(2'd2, v); chk(v == 8'h24, "R8", "received byte", v, 8'h24);
    bus_read(2'd1, v); chk(v[0] == 1'b1, "R8", "flag kept without status read", v[0], 1);
    bus_read(2'd2, v);
    bus_read(2'd1, v); chk(v[0] == 1'b0, "R8", "flag cleared after sequence", v[0], 0);

    // R9 abort by disabling mid-exchange
    bus_write(2'd0, {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1});
    arm_slave(0, 0, 8'h11);
    bus_write(2'd2, 8'hE7);
    repeat (30) @(negedge clk);
    s_active = 0;
    bus_write(2'd0, {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    repeat (5) @(negedge clk);
    chk(sck == 1'b1, "R9", "sck at cpol after abort", sck, 1);
    bus_read(2'd1, v); chk(v[0] == 1'b0, "R9", "no completion after abort", v[0], 0);

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule